// File: doc/BRIEF.md
# DRAM Command Sequencer

This block runs a short stored program of DRAM commands and drives each one onto a memory command bus. A host loads an instruction store of up to 32 entries through a simple write port. Each entry has two 64-bit words: a command word that holds the pin values, and a control word that holds the wait, loop and branch settings. The host then writes a start bit. The engine walks the program from entry 0 until it finishes an entry whose end flag is set, and then reports pass or fail in a six-bit status vector.

Each entry can do four things: issue one command cycle, optionally wait for an external calibration handshake, pad with deselect cycles, and loop on itself before it branches to its goto target. A read-compare stub input and an uncorrectable-error stub input stand in for the data path. A mode register sets the halt-on-error policy, the calibration time limit and the level of the DRAM reset pin.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset, status reads 0. The bus shows a deselect: every chip select high, RAS_n, CAS_n and WE_n high, address 0 and activate 0. The DRAM reset pin is low.
- R2: In an issue cycle, the bus carries the fields of the current entry's command word. The positions are: address [15:0], bank [19:17], activate [20], RAS_n [21], CAS_n [22], WE_n [23], CKE [31:24], chip selects [47:32], ODT [55:48] and calibration type [59:56]. The data pattern [51:32] of the control word appears on cmd_wdata. The first issue happens in the cycle after the start write.
- R3: Every issue is followed by exactly idle-count deselect cycles. The idle count is in control word [15:0].
- R4: A repeat count N (control word [31:16]) makes the entry issue N+1 times. Each issue has its own calibration wait and idle wait.
- R5: When an entry completes, execution goes to the index in control word [63:59]. If the end flag [58] is set, the engine stops instead and sets pass (no error seen) or fail.
- R6: The host writes control through reg_sel=3. Data bit 0 starts the program at entry 0 when the engine is idle, and clears the earlier results. Data bit 1 stops the engine at the next edge. If both bits are set, stop wins and no start occurs.
- R7: The status bits are: [0] in progress, [1] passed, [2] failed, [3] read miscompare, [4] uncorrectable error, [5] calibration timeout. Pass and fail both read 0 while the program runs.
- R8: In an issue cycle of an entry with read-compare set (control bit 52), rd_mismatch sets cause [3] and ue_err sets cause [4]. Unless halt-on-error is on, the program keeps running and ends with fail.
- R9: With halt-on-error on (mode bit 0), an error stops the engine at the next edge with fail set.
- R10: An entry with calibration enable set (control bit 57) raises cal_busy after its issue, with cal_rank taken from control [56:53], and holds the bus deselected. The wait ends when cal_done is high. If cal_done is still low after max(T,1) cycles, the wait ends with a timeout (cause [5]). T is the mode field [23:8].
- R11: Writes to the instruction store (reg_sel 0 for the command word, 1 for the control word) are ignored while the program runs.
- R12: A mode write (reg_sel=2) sets dram_reset_n to data bit 24 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Host write strobe |
| reg_sel | input | 2 | 0 command word, 1 control word, 2 mode, 3 control |
| reg_idx | input | 5 | Instruction entry index |
| reg_wdata | input | 64 | Host write data |
| status | output | 6 | Busy, pass, fail and fail causes |
| rd_mismatch | input | 1 | Read-compare stub: data mismatch |
| ue_err | input | 1 | Read-compare stub: uncorrectable error |
| cal_done | input | 1 | Calibration handshake complete |
| cal_busy | output | 1 | Engine is waiting for calibration |
| cal_rank | output | 4 | Rank under calibration |
| cmd_addr | output | 16 | DRAM address |
| cmd_bank | output | 3 | Bank address |
| cmd_act | output | 1 | Activate |
| cmd_ras_n | output | 1 | RAS_n |
| cmd_cas_n | output | 1 | CAS_n |
| cmd_we_n | output | 1 | WE_n |
| cmd_cke | output | 8 | Clock enables, held between issues |
| cmd_cs_n | output | 16 | Chip selects, two ports of eight |
| cmd_odt | output | 8 | On-die termination |
| cmd_cal_type | output | 4 | Calibration type code |
| cmd_wdata | output | 20 | Data pattern of the issuing entry |
| dram_reset_n | output | 1 | DRAM reset pin level |

## Verification
The main walk is tried with random programs. These programs mix idle counts from 0 to 3, repeat counts from 0 to 2 and forward gotos that skip entries. Each one is compared cycle by cycle against a timeline the bench expands from the program, so a wrong idle count, a missing repeat or a wrong branch each shows up as a shifted or missing issue. Directed programs cover the error paths: a miscompare and an uncorrectable error with halting off, which must still run to the end, and a miscompare with halting on, which must stop at once. They also cover a calibration wait that ends at once and one that times out, which shift the timeline by different amounts. Further directed cases check a stop in the middle of a long wait, a simultaneous start and stop, and a store write made while the program runs.

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq #(
  parameter int ENTRIES = 32,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [IW-1:0] reg_idx,
  input  logic [63:0]   reg_wdata,
  output logic [5:0]    status,
  input  logic          rd_mismatch,
  input  logic          ue_err,
  input  logic          cal_done,
  output logic          cal_busy,
  output logic [3:0]    cal_rank,
  output logic [15:0]   cmd_addr,
  output logic [2:0]    cmd_bank,
  output logic          cmd_act,
  output logic          cmd_ras_n,
  output logic          cmd_cas_n,
  output logic          cmd_we_n,
  output logic [7:0]    cmd_cke,
  output logic [15:0]   cmd_cs_n,
  output logic [7:0]    cmd_odt,
  output logic [3:0]    cmd_cal_type,
  output logic [19:0]   cmd_wdata,
  output logic          dram_reset_n
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_CAL, S_WAIT} state_t;

  state_t st, nst;
  logic [63:0] w0_mem [ENTRIES];
  logic [63:0] w1_mem [ENTRIES];
  logic [63:0] w0, w1;
  logic [IW-1:0] pc, npc;
  logic [15:0] rep_q, nrep, cnt_q, ncnt, cal_time;
  logic [7:0] cke_q;
  logic soe, rstn_q, pass_q, fail_q, mis_q, ue_q, to_q;
  logic busy, issue, calw, fin, post, adv;
  logic ctrl_wr, start_req, stop_req, mis_now, ue_now, to_now, halt_err, any_err;

  logic [15:0]   idle, rep;
  logic          rdcmp, calen, endf;
  logic [IW-1:0] gto;

  assign w0 = w0_mem[pc];
  assign w1 = w1_mem[pc];
  assign idle  = w1[15:0];
  assign rep   = w1[31:16];
  assign rdcmp = w1[52];
  assign calen = w1[57];
  assign endf  = w1[58];
  assign gto   = w1[59 +: IW];

  assign busy  = (st != S_IDLE);
  assign issue = (st == S_ISSUE);
  assign calw  = (st == S_CAL);

  assign ctrl_wr   = reg_we && (reg_sel == 2'd3);
  assign start_req = ctrl_wr && reg_wdata[0] && !reg_wdata[1];
  assign stop_req  = ctrl_wr && reg_wdata[1];
  assign mis_now   = issue && rdcmp && rd_mismatch;
  assign ue_now    = issue && rdcmp && ue_err;
  assign to_now    = calw && !cal_done && (({1'b0, cnt_q} + 17'd1) >= {1'b0, cal_time});
  assign halt_err  = soe && (mis_now || ue_now || to_now);
  assign any_err   = mis_q || ue_q || to_q || mis_now || ue_now || to_now;

  always_comb begin
    nst  = st;
    npc  = pc;
    nrep = rep_q;
    ncnt = cnt_q + 16'd1;
    fin  = 1'b0;
    post = 1'b0;
    adv  = 1'b0;
    case (st)
      S_ISSUE: if (calen) begin
                 nst  = S_CAL;
                 ncnt = '0;
               end else post = 1'b1;
      S_CAL:   post = cal_done || to_now;
      S_WAIT:  adv = (cnt_q == idle - 16'd1);
      default: ;
    endcase
    if (post) begin
      if (idle != 16'd0) begin
        nst  = S_WAIT;
        ncnt = '0;
      end else adv = 1'b1;
    end
    if (adv) begin
      if (rep_q != rep) begin
        nrep = rep_q + 16'd1;
        nst  = S_ISSUE;
      end else begin
        nrep = '0;
        if (endf) begin
          fin = 1'b1;
          nst = S_IDLE;
        end else begin
          npc = gto;
          nst = S_ISSUE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (reg_we && !busy && !reg_sel[1]) begin
      if (reg_sel[0]) w1_mem[reg_idx] <= reg_wdata;
      else            w0_mem[reg_idx] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pc <= '0;
      rep_q <= '0;
      cnt_q <= '0;
      cke_q <= '0;
      soe <= 1'b0;
      cal_time <= '0;
      rstn_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      mis_q <= 1'b0;
      ue_q <= 1'b0;
      to_q <= 1'b0;
    end else begin
      if (reg_we && reg_sel == 2'd2) begin
        soe      <= reg_wdata[0];
        cal_time <= reg_wdata[23:8];
        rstn_q   <= reg_wdata[24];
      end
      if (issue) cke_q <= w0[31:24];
      if (busy) begin
        if (stop_req) begin
          st    <= S_IDLE;
          rep_q <= '0;
        end else begin
          mis_q <= mis_q || mis_now;
          ue_q  <= ue_q || ue_now;
          to_q  <= to_q || to_now;
          if (halt_err) begin
            st     <= S_IDLE;
            rep_q  <= '0;
            fail_q <= 1'b1;
          end else begin
            st    <= nst;
            pc    <= npc;
            rep_q <= nrep;
            cnt_q <= ncnt;
            if (fin) begin
              pass_q <= !any_err;
              fail_q <= any_err;
            end
          end
        end
      end else if (start_req) begin
        st <= S_ISSUE;
        pc <= '0;
        rep_q <= '0;
        cnt_q <= '0;
        pass_q <= 1'b0;
        fail_q <= 1'b0;
        mis_q <= 1'b0;
        ue_q <= 1'b0;
        to_q <= 1'b0;
      end
    end
  end

  assign status       = {to_q, ue_q, mis_q, fail_q, pass_q, busy};
  assign cal_busy     = calw;
  assign cal_rank     = calw ? w1[56:53] : 4'd0;
  assign cmd_addr     = issue ? w0[15:0] : 16'd0;
  assign cmd_bank     = issue ? w0[19:17] : 3'd0;
  assign cmd_act      = issue & w0[20];
  assign cmd_ras_n    = issue ? w0[21] : 1'b1;
  assign cmd_cas_n    = issue ? w0[22] : 1'b1;
  assign cmd_we_n     = issue ? w0[23] : 1'b1;
  assign cmd_cke      = issue ? w0[31:24] : cke_q;
  assign cmd_cs_n     = issue ? w0[47:32] : 16'hFFFF;
  assign cmd_odt      = issue ? w0[55:48] : 8'd0;
  assign cmd_cal_type = issue ? w0[59:56] : 4'd0;
  assign cmd_wdata    = issue ? w1[51:32] : 20'd0;
  assign dram_reset_n = rstn_q;

  logic unused_bits;
  assign unused_bits = ^{w0[16], w0[63:60], reg_wdata[63:25], reg_wdata[7:1]};

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy) |=> status[0]) else $error("start did not run"); // R6
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !status[0]) else $error("stop ignored"); // R6
  AST_RESULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (!status[1] && !status[2])) else $error("result while busy"); // R7
  AST_END_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fin && !stop_req && !halt_err) |=> (!status[0] && (status[1] != status[2])))
    else $error("no verdict at end"); // R5
  AST_HALT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && halt_err && !stop_req) |=> (!status[0] && status[2])) else $error("no halt"); // R9
  AST_CAL_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> (&cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n)) else $error("bus active in cal"); // R10
  AST_RESET_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd2) |=> (dram_reset_n == $past(reg_wdata[24]))) else $error("reset pin"); // R12

endmodule

// File: tb/dram_cmd_seq_test.sv
module dram_cmd_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [4:0] reg_idx = '0;
  logic [63:0] reg_wdata = '0;
  logic rd_mismatch = 1'b0, ue_err = 1'b0, cal_done = 1'b1;
  logic [5:0] status;
  logic cal_busy;
  logic [3:0] cal_rank, cmd_cal_type;
  logic [15:0] cmd_addr, cmd_cs_n;
  logic [2:0] cmd_bank;
  logic cmd_act, cmd_ras_n, cmd_cas_n, cmd_we_n, dram_reset_n;
  logic [7:0] cmd_cke, cmd_odt;
  logic [19:0] cmd_wdata;

  int checks = 0, errors = 0;
  logic [63:0] b0 [32];
  logic [63:0] b1 [32];
  int expk [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .status(status), .rd_mismatch(rd_mismatch), .ue_err(ue_err),
    .cal_done(cal_done), .cal_busy(cal_busy), .cal_rank(cal_rank), .cmd_addr(cmd_addr),
    .cmd_bank(cmd_bank), .cmd_act(cmd_act), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
    .cmd_we_n(cmd_we_n), .cmd_cke(cmd_cke), .cmd_cs_n(cmd_cs_n), .cmd_odt(cmd_odt),
    .cmd_cal_type(cmd_cal_type), .cmd_wdata(cmd_wdata), .dram_reset_n(dram_reset_n)
  );

  function automatic logic [63:0] mk0(logic [15:0] a, logic [2:0] bk, logic act, logic ras,
      logic cas, logic we, logic [7:0] cke, logic [15:0] cs, logic [7:0] odt, logic [3:0] ct);
    logic [63:0] w = '0;
    w[15:0] = a; w[19:17] = bk; w[20] = act; w[21] = ras; w[22] = cas; w[23] = we;
    w[31:24] = cke; w[47:32] = cs; w[55:48] = odt; w[59:56] = ct;
    return w;
  endfunction

  function automatic logic [63:0] mk1(logic [15:0] idl, logic [15:0] rp, logic [19:0] pat,
      logic rdc, logic [3:0] rk, logic cal, logic e, logic [4:0] g);
    logic [63:0] w = '0;
    w[15:0] = idl; w[31:16] = rp; w[51:32] = pat; w[52] = rdc; w[56:53] = rk;
    w[57] = cal; w[58] = e; w[63:59] = g;
    return w;
  endfunction

  function automatic logic [63:0] mode(logic soe, logic [15:0] t, logic rn);
    logic [63:0] w = '0;
    w[0] = soe; w[23:8] = t; w[24] = rn;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [1:0] sel, input int idx, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_idx = 5'(idx); reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic wr_ins(input logic [1:0] sel, input int idx, input logic [63:0] d);
    wr_raw(sel, idx, d);
    if (sel == 2'd0) b0[idx] = d; else b1[idx] = d;
  endtask

  task automatic run_check(input string req, input int cal_len, input logic [5:0] exp_st,
                           input bit probe_cal, input logic [3:0] exp_rank);
    int pc = 0, t = 0, steps = 0, bad = 0;
    for (int i = 0; i < 1024; i++) expk[i] = -1;
    while (steps < 64 && t < 900) begin
      for (int r = 0; r <= int'(b1[pc][31:16]); r++) begin
        expk[t] = pc;
        t += 1 + (b1[pc][57] ? cal_len : 0) + int'(b1[pc][15:0]);
      end
      steps++;
      if (b1[pc][58]) break;
      pc = int'(b1[pc][63:59]);
    end
    wr_raw(2'd3, 0, 64'h1);
    for (int k = 0; k < t; k++) begin
      bit ok;
      @(negedge clk);
      if (expk[k] >= 0) begin
        int p = expk[k];
        ok = cmd_addr == b0[p][15:0] && cmd_bank == b0[p][19:17] && cmd_act == b0[p][20] &&
             cmd_ras_n == b0[p][21] && cmd_cas_n == b0[p][22] && cmd_we_n == b0[p][23] &&
             cmd_cke == b0[p][31:24] && cmd_cs_n == b0[p][47:32] && cmd_odt == b0[p][55:48] &&
             cmd_cal_type == b0[p][59:56] && cmd_wdata == b1[p][51:32];
      end else begin
        ok = cmd_cs_n == 16'hFFFF && cmd_ras_n && cmd_cas_n && cmd_we_n && !cmd_act &&
             cmd_addr == 16'd0;
      end
      ok = ok && status[0];
      if (!ok && bad == 0)
        $display("FAIL %s trace cycle %0d: actual cs=%0h addr=%0h st=%0h expected entry %0d",
                 req, k, cmd_cs_n, cmd_addr, status, expk[k]);
      if (!ok) bad++;
      if (probe_cal && k == 1)
        chk(cal_busy && cal_rank == exp_rank, "R10", "cal_busy/cal_rank",
            {cal_busy, cal_rank}, {1'b1, exp_rank});
    end
    checks++;
    if (bad != 0) errors++;
    @(negedge clk);
    chk(status == exp_st, req, "final status", status, exp_st);
  endtask

  task automatic rand_prog();
    int cur = 0;
    int n = 1 + int'($urandom % 5);
    for (int i = 0; i < n; i++) begin
      int nx = cur + 1 + int'($urandom % 3);
      bit last = (i == n - 1) || (nx > 31);
      wr_ins(2'd0, cur, mk0(16'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), 8'($urandom), 16'($urandom), 8'($urandom), 4'($urandom)));
      wr_ins(2'd1, cur, mk1(16'($urandom % 4), 16'($urandom % 3), 20'($urandom), 1'b0, 4'd0,
             1'b0, last, last ? 5'd0 : 5'(nx)));
      if (last) break;
      cur = nx;
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [63:0] nop0, nop1;
    void'($urandom(32'd4242));
    nop0 = mk0(16'd0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 16'hFFFF, 8'd0, 4'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R12 pin low after reset
    chk(status == 6'd0, "R1", "status", status, 0);
    chk(cmd_cs_n == 16'hFFFF && cmd_ras_n && cmd_cas_n && cmd_we_n && !cmd_act && cmd_addr == 0,
        "R1", "deselect", {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, {16'hFFFF, 3'b111});
    chk(dram_reset_n == 1'b0, "R1", "dram_reset_n", dram_reset_n, 0);

    wr_raw(2'd2, 0, mode(1'b0, 16'd5, 1'b1));
    @(negedge clk);
    chk(dram_reset_n == 1'b1, "R12", "dram_reset_n", dram_reset_n, 1);

    // R2 R3 R4 R5 R7: random programs
    for (int i = 0; i < 8; i++) begin
      rand_prog();
      run_check("R2/R3/R4/R5", 0, 6'b000010, 1'b0, 4'd0);
    end

    // R5 directed skip and loop
    wr_ins(2'd0, 0, mk0(16'h1234, 3'd5, 1'b1, 1'b0, 1'b1, 1'b1, 8'h0F, 16'hFFFE, 8'h01, 4'd2));
    wr_ins(2'd1, 0, mk1(16'd2, 16'd1, 20'hABCDE, 1'b0, 4'd0, 1'b0, 1'b0, 5'd7));
    wr_ins(2'd0, 7, nop0);
    wr_ins(2'd1, 7, mk1(16'd0, 16'd2, 20'd0, 1'b0, 4'd0, 1'b0, 1'b1, 5'd0));
    run_check("R5", 0, 6'b000010, 1'b0, 4'd0);

    // R8 miscompare without halting
    nop1 = mk1(16'd0, 16'd0, 20'd0, 1'b0, 4'd0, 1'b0, 1'b1, 5'd0);
    wr_ins(2'd0, 0, mk0(16'h0400, 3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 16'hFFFD, 8'd0, 4'd0));
    wr_ins(2'd1, 0, mk1(16'd1, 16'd0, 20'h55555, 1'b1, 4'd0, 1'b0, 1'b0, 5'd1));
    wr_ins(2'd0, 1, nop0);
    wr_ins(2'd1, 1, nop1);
    rd_mismatch = 1'b1;
    run_check("R8", 0, 6'b001100, 1'b0, 4'd0);
    rd_mismatch = 1'b0;
    ue_err = 1'b1;
    run_check("R8", 0, 6'b010100, 1'b0, 4'd0);
    ue_err = 1'b0;

    // R9 halt on error
    wr_raw(2'd2, 0, mode(1'b1, 16'd5, 1'b1));
    rd_mismatch = 1'b1;
    wr_raw(2'd3, 0, 64'h1);
    @(negedge clk);
    chk(cmd_cs_n == 16'hFFFD, "R9", "issue before halt", cmd_cs_n, 16'hFFFD);
    @(negedge clk);
    chk(status == 6'b001100, "R9", "halted status", status, 6'b001100);
    rd_mismatch = 1'b0;
    wr_raw(2'd2, 0, mode(1'b0, 16'd5, 1'b1));

    // R10 calibration handshake and timeout
    wr_ins(2'd1, 0, mk1(16'd1, 16'd0, 20'd0, 1'b0, 4'd3, 1'b1, 1'b0, 5'd1));
    cal_done = 1'b1;
    run_check("R10", 1, 6'b000010, 1'b1, 4'd3);
    cal_done = 1'b0;
    run_check("R10", 5, 6'b100100, 1'b1, 4'd3);
    cal_done = 1'b1;

    // R6 stop during a long wait
    wr_ins(2'd0, 0, mk0(16'hAAAA, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 16'hFFFE, 8'd0, 4'd0));
    wr_ins(2'd1, 0, mk1(16'd200, 16'd0, 20'd0, 1'b0, 4'd0, 1'b0, 1'b1, 5'd0));
    wr_raw(2'd3, 0, 64'h1);
    @(negedge clk);
    @(negedge clk);
    chk(status == 6'b000001, "R6", "running", status, 6'b000001);
    // R11 store write while running must be dropped
    wr_raw(2'd0, 0, mk0(16'h5555, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 16'hFFFE, 8'd0, 4'd0));
    wr_raw(2'd3, 0, 64'h2);
    @(negedge clk);
    chk(status == 6'd0 && cmd_cs_n == 16'hFFFF, "R6", "stopped", {status, cmd_cs_n}, {6'd0, 16'hFFFF});
    wr_ins(2'd1, 0, mk1(16'd0, 16'd0, 20'd0, 1'b0, 4'd0, 1'b0, 1'b1, 5'd0));
    run_check("R11", 0, 6'b000010, 1'b0, 4'd0);

    // R6 start and stop together while idle
    wr_raw(2'd3, 0, 64'h3);
    @(negedge clk);
    chk(status[0] == 1'b0 && cmd_cs_n == 16'hFFFF, "R6", "start+stop", status, 6'b000010);

    finish_up();
  end
endmodule